// File: doc/BRIEF.md
# Parallel-Port Peripheral Register Interface

This block is the peripheral end of a byte-wide parallel-port link that runs in the enhanced (address/data strobe) mode. After reset it waits for a short mode-negotiation exchange with the host. Once that exchange is done, it serves address cycles and data cycles. Each cycle is a four-phase handshake: the host lowers a strobe, the block raises `busy_o`, the host releases the strobe, and the block lowers `busy_o`. The direction line tells the block whether a data cycle writes or reads.

The address cycle selects a 16-bit register. Two data cycles then carry that register, low byte first. Six configuration registers are writable and drive the acquisition logic through dedicated output ports. Two words are read-only. The first is a status word built from the sample, run and error inputs. The second is an error number.

The host lines are asynchronous to the block, so they pass through a synchroniser before they are decoded. A synchronous reset returns the block to the negotiation-wait state and clears every configuration register.

Top module: `epp_regif`

## Requirements
- R1: While `rst` is high and after it is released, `busy_o`=0, `sel_o`=0, `perr_o`=0, `ack_n_o`=1, `fault_n_o`=1, `data_oe_o`=0, and every configuration output is zero.
- R2: In negotiation-wait, the block answers with `perr_o`=1, `ack_n_o`=0, `fault_n_o`=1 and `sel_o`=1 when three host conditions hold together: the host drives 0x40 on `host_data_i`, `host_astb_n_i` is high, and `host_dstb_n_i` is low.
- R3: Once acknowledged, the host sends a low pulse on `host_wr_n_i`, then raises both `host_wr_n_i` and `host_dstb_n_i`. The block then enters enhanced mode with `ack_n_o`=1, `sel_o`=1 and `perr_o`=0. Before this point, a strobe never raises `busy_o`.
- R4: In enhanced mode, a low `host_astb_n_i` latches `host_data_i` as the register address and raises `busy_o`. `busy_o` falls after the strobe returns high.
- R5: A data cycle with `host_wr_n_i` low writes one byte. The first data cycle after an address cycle is bits 7:0 and is only staged. The second is bits 15:8 and updates the whole register in one step. A configuration output never shows a half-written value.
- R6: `data_oe_o` is high only during a read data cycle (`host_wr_n_i` high) while `busy_o` is high. `data_o` then holds the addressed byte.
- R7: The configuration registers and their implemented bits are:
  - 0: run, bits 10:0
  - 1: channel select, bits 1:0
  - 2: buffer size, bits 13:0
  - 3: trigger level, bits 9:0
  - 4: trigger offset, bits 14:0
  - 5: converter setup, bits 11:0

  Unimplemented bits read as zero.
- R8: Address 8 reads the status word: `st_err_i` in bit 15, `st_run_i` in bit 14, `st_chan_i` in bit 10, `st_sample_i` in bits 9:0, and zero elsewhere.
- R9: Address 9 reads `err_num_i` in bits 2:0 and zero elsewhere.
- R10: Writes to addresses 8, 9 and any unmapped address change no register. Unmapped addresses read as zero.
- R11: The 16-bit value is captured when its low byte is read. The following high-byte read returns that captured value, even if the inputs changed in between.
- R12: A negotiation attempt with any byte other than 0x40 leaves the block in negotiation-wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| host_data_i | input | 8 | Byte driven by the host |
| host_wr_n_i | input | 1 | Direction: low = write, high = read |
| host_astb_n_i | input | 1 | Address strobe, active low |
| host_dstb_n_i | input | 1 | Data strobe, active low |
| data_o | output | 8 | Byte returned on a read |
| data_oe_o | output | 1 | Enable for the bus drivers on a read |
| busy_o | output | 1 | Handshake reply to a strobe |
| ack_n_o | output | 1 | Negotiation acknowledge, active low |
| perr_o | output | 1 | Negotiation reply flag |
| sel_o | output | 1 | Peripheral selected / mode active |
| fault_n_o | output | 1 | Fault line, held high |
| st_err_i | input | 1 | Error flag for the status word |
| st_run_i | input | 1 | Run flag for the status word |
| st_chan_i | input | 1 | Channel of the current sample |
| st_sample_i | input | 10 | Current sample value |
| err_num_i | input | 3 | Error number |
| cfg_run_o | output | 11 | Register 0 |
| cfg_chan_o | output | 2 | Register 1 |
| cfg_bufsize_o | output | 14 | Register 2 |
| cfg_trig_lvl_o | output | 10 | Register 3 |
| cfg_trig_off_o | output | 15 | Register 4 |
| cfg_adc_o | output | 12 | Register 5 |

## Verification
The hardest case to reach is a status word that changes between its two byte reads. The bench reaches it by stopping after the low-byte handshake and changing the status inputs while the link sits idle. It then runs the second data cycle and expects the old high byte. The half-written register is reached in a similar way. The bench issues one data cycle only and inspects the configuration port before sending the high byte. Negotiation is first driven with a wrong byte and with a bare address strobe, to show that the block does not leave the wait state too early.

// File: rtl/epp_regif_pkg.sv
package epp_regif_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 8;
    localparam int NUM_CFG   = 6;
    localparam int SAMPLE_W  = 10;
    localparam int ERR_W     = 3;
    localparam int STAT_ADDR = 8;
    localparam int ERRN_ADDR = 9;
    localparam logic [BYTE_W-1:0] NEG_CODE = 8'h40;

    typedef enum logic [2:0] {
        L_NEG_WAIT, L_NEG_ACK, L_NEG_STB, L_IDLE, L_ADDR, L_DATA
    } link_st_e;

    typedef struct packed {
        link_st_e             st;
        logic [ADDR_W-1:0]    addr;
        logic                 hi;
        logic                 busy;
        logic                 oe;
        logic [WORD_W-1:0]    snap;
        logic [BYTE_W-1:0]    dout;
    } link_s;

    typedef struct packed {
        logic [BYTE_W-1:0]                stage;
        logic [NUM_CFG-1:0][WORD_W-1:0]   cfg;
    } bank_s;

    function automatic logic [WORD_W-1:0] cfg_mask(input int idx);
        case (idx)
            0:       return 16'h07FF;
            1:       return 16'h0003;
            2:       return 16'h3FFF;
            3:       return 16'h03FF;
            4:       return 16'h7FFF;
            5:       return 16'h0FFF;
            default: return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/epp_link.sv
module epp_link
    import epp_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n_s,
    input  logic              astb_n_s,
    input  logic              dstb_n_s,
    input  logic [BYTE_W-1:0] host_data,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              wr_hi,
    output logic [BYTE_W-1:0] wr_byte,
    output logic [BYTE_W-1:0] dout,
    output logic              oe,
    output logic              busy,
    output logic              ack_n,
    output logic              perr,
    output logic              sel,
    output logic              fault_n
);
    link_s lk_d, lk_q;

    always_comb begin
        lk_d  = lk_q;
        wr_en = 1'b0;
        case (lk_q.st)
            L_NEG_WAIT: begin
                if (host_data == NEG_CODE && astb_n_s && !dstb_n_s)
                    lk_d.st = L_NEG_ACK;
            end
            L_NEG_ACK: begin
                if (!wr_n_s) lk_d.st = L_NEG_STB;
            end
            L_NEG_STB: begin
                if (wr_n_s && dstb_n_s) lk_d.st = L_IDLE;
            end
            L_IDLE: begin
                if (!astb_n_s) begin
                    lk_d.addr = host_data;
                    lk_d.hi   = 1'b0;
                    lk_d.busy = 1'b1;
                    lk_d.st   = L_ADDR;
                end else if (!dstb_n_s) begin
                    lk_d.busy = 1'b1;
                    lk_d.st   = L_DATA;
                    if (wr_n_s) begin
                        lk_d.oe = 1'b1;
                        if (!lk_q.hi) begin
                            lk_d.snap = rd_word;
                            lk_d.dout = rd_word[BYTE_W-1:0];
                        end else begin
                            lk_d.dout = lk_q.snap[WORD_W-1:BYTE_W];
                        end
                    end else begin
                        wr_en = 1'b1;
                    end
                end
            end
            L_ADDR: begin
                if (astb_n_s) begin
                    lk_d.busy = 1'b0;
                    lk_d.st   = L_IDLE;
                end
            end
            L_DATA: begin
                if (dstb_n_s) begin
                    lk_d.busy = 1'b0;
                    lk_d.oe   = 1'b0;
                    lk_d.hi   = !lk_q.hi;
                    lk_d.st   = L_IDLE;
                end
            end
            default: lk_d.st = L_NEG_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_q    <= '0;
            lk_q.st <= L_NEG_WAIT;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign addr    = lk_q.addr;
    assign wr_hi   = lk_q.hi;
    assign wr_byte = host_data;
    assign dout    = lk_q.dout;
    assign oe      = lk_q.oe;
    assign busy    = lk_q.busy;
    assign perr    = (lk_q.st == L_NEG_ACK) || (lk_q.st == L_NEG_STB);
    assign ack_n   = !perr;
    assign sel     = (lk_q.st != L_NEG_WAIT);
    assign fault_n = 1'b1;
endmodule

// File: rtl/epp_regbank.sv
module epp_regbank
    import epp_regif_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic                           wr_hi,
    input  logic [BYTE_W-1:0]              wr_byte,
    input  logic                           st_err,
    input  logic                           st_run,
    input  logic                           st_chan,
    input  logic [SAMPLE_W-1:0]            st_sample,
    input  logic [ERR_W-1:0]               err_num,
    output logic [WORD_W-1:0]              rd_word,
    output logic [NUM_CFG-1:0][WORD_W-1:0] cfg
);
    bank_s bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en) begin
            if (!wr_hi) begin
                bk_d.stage = wr_byte;
            end else begin
                for (int i = 0; i < NUM_CFG; i++) begin
                    if (addr == ADDR_W'(i))
                        bk_d.cfg[i] = {wr_byte, bk_q.stage} & cfg_mask(i);
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CFG; i++) begin
            if (addr == ADDR_W'(i)) rd_word = bk_q.cfg[i];
        end
        if (addr == ADDR_W'(STAT_ADDR)) begin
            rd_word[15]             = st_err;
            rd_word[14]             = st_run;
            rd_word[10]             = st_chan;
            rd_word[SAMPLE_W-1:0]   = st_sample;
        end
        if (addr == ADDR_W'(ERRN_ADDR)) begin
            rd_word[ERR_W-1:0] = err_num;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bk_q <= '0;
        else     bk_q <= bk_d;
    end

    assign cfg = bk_q.cfg;
endmodule

// File: rtl/epp_regif.sv
module epp_regif
    import epp_regif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   host_data_i,
    input  logic                host_wr_n_i,
    input  logic                host_astb_n_i,
    input  logic                host_dstb_n_i,
    output logic [BYTE_W-1:0]   data_o,
    output logic                data_oe_o,
    output logic                busy_o,
    output logic                ack_n_o,
    output logic                perr_o,
    output logic                sel_o,
    output logic                fault_n_o,
    input  logic                st_err_i,
    input  logic                st_run_i,
    input  logic                st_chan_i,
    input  logic [SAMPLE_W-1:0] st_sample_i,
    input  logic [ERR_W-1:0]    err_num_i,
    output logic [10:0]         cfg_run_o,
    output logic [1:0]          cfg_chan_o,
    output logic [13:0]         cfg_bufsize_o,
    output logic [9:0]          cfg_trig_lvl_o,
    output logic [14:0]         cfg_trig_off_o,
    output logic [11:0]         cfg_adc_o
);
    logic [2:0]                     strobes_s;
    logic [ADDR_W-1:0]              addr;
    logic                           wr_en, wr_hi;
    logic [BYTE_W-1:0]              wr_byte;
    logic [WORD_W-1:0]              rd_word;
    logic [NUM_CFG-1:0][WORD_W-1:0] cfg;

    epp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({host_wr_n_i, host_astb_n_i, host_dstb_n_i}),
        .q_o (strobes_s)
    );

    epp_link u_link (
        .clk       (clk),
        .rst       (rst),
        .wr_n_s    (strobes_s[2]),
        .astb_n_s  (strobes_s[1]),
        .dstb_n_s  (strobes_s[0]),
        .host_data (host_data_i),
        .rd_word   (rd_word),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .wr_byte   (wr_byte),
        .dout      (data_o),
        .oe        (data_oe_o),
        .busy      (busy_o),
        .ack_n     (ack_n_o),
        .perr      (perr_o),
        .sel       (sel_o),
        .fault_n   (fault_n_o)
    );

    epp_regbank u_bank (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_hi     (wr_hi),
        .wr_byte   (wr_byte),
        .st_err    (st_err_i),
        .st_run    (st_run_i),
        .st_chan   (st_chan_i),
        .st_sample (st_sample_i),
        .err_num   (err_num_i),
        .rd_word   (rd_word),
        .cfg       (cfg)
    );

    assign cfg_run_o      = cfg[0][10:0];
    assign cfg_chan_o     = cfg[1][1:0];
    assign cfg_bufsize_o  = cfg[2][13:0];
    assign cfg_trig_lvl_o = cfg[3][9:0];
    assign cfg_trig_off_o = cfg[4][14:0];
    assign cfg_adc_o      = cfg[5][11:0];
endmodule

// File: rtl/epp_regif_chk.sv
module epp_regif_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        data_oe_o,
    input logic        sel_o,
    input logic        perr_o,
    input logic        ack_n_o,
    input logic [10:0] cfg_run_o,
    input logic [13:0] cfg_bufsize_o
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !sel_o && !perr_o));

    // R3
    busy_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> sel_o);

    // R2
    neg_reply_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n_o) |-> (perr_o && sel_o));

    // R6
    drive_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> busy_o);

    // R5
    run_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_run_o) |-> busy_o);

    // R5
    bufsize_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bufsize_o) |-> busy_o);
endmodule

bind epp_regif epp_regif_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .busy_o        (busy_o),
    .data_oe_o     (data_oe_o),
    .sel_o         (sel_o),
    .perr_o        (perr_o),
    .ack_n_o       (ack_n_o),
    .cfg_run_o     (cfg_run_o),
    .cfg_bufsize_o (cfg_bufsize_o)
);

// File: tb/epp_regif_bench.sv
module epp_regif_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  host_data = 8'h00;
    logic        wr_n = 1'b1, astb_n = 1'b1, dstb_n = 1'b1;
    logic [7:0]  data_o;
    logic        data_oe_o, busy_o, ack_n_o, perr_o, sel_o, fault_n_o;
    logic        st_err = 1'b1, st_run = 1'b1, st_chan = 1'b1;
    logic [9:0]  st_sample = 10'h2AB;
    logic [2:0]  err_num = 3'd5;
    logic [10:0] cfg_run;
    logic [1:0]  cfg_chan;
    logic [13:0] cfg_bufsize;
    logic [9:0]  cfg_trig_lvl;
    logic [14:0] cfg_trig_off;
    logic [11:0] cfg_adc;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    epp_regif u_epp_regif (
        .clk(clk), .rst(rst), .host_data_i(host_data), .host_wr_n_i(wr_n),
        .host_astb_n_i(astb_n), .host_dstb_n_i(dstb_n), .data_o(data_o),
        .data_oe_o(data_oe_o), .busy_o(busy_o), .ack_n_o(ack_n_o), .perr_o(perr_o),
        .sel_o(sel_o), .fault_n_o(fault_n_o), .st_err_i(st_err), .st_run_i(st_run),
        .st_chan_i(st_chan), .st_sample_i(st_sample), .err_num_i(err_num),
        .cfg_run_o(cfg_run), .cfg_chan_o(cfg_chan), .cfg_bufsize_o(cfg_bufsize),
        .cfg_trig_lvl_o(cfg_trig_lvl), .cfg_trig_off_o(cfg_trig_off), .cfg_adc_o(cfg_adc)
    );

    typedef struct packed {
        logic [7:0]  a;
        logic        wr;
        logic [15:0] w;
        logic [15:0] e;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'd0, 1'b1, 16'hFFFF, 16'h07FF},
        '{8'd1, 1'b1, 16'hFFFF, 16'h0003},
        '{8'd2, 1'b1, 16'hFFFF, 16'h3FFF},
        '{8'd3, 1'b1, 16'hFFFF, 16'h03FF},
        '{8'd4, 1'b1, 16'hFFFF, 16'h7FFF},
        '{8'd5, 1'b1, 16'hFFFF, 16'h0FFF},
        '{8'd2, 1'b1, 16'h1234, 16'h1234},
        '{8'd8, 1'b1, 16'h5555, 16'hC6AB},
        '{8'd9, 1'b1, 16'hFFFF, 16'h0005},
        '{8'd7, 1'b1, 16'hFFFF, 16'h0000},
        '{8'd0, 1'b1, 16'hA55A, 16'h055A}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic wait_busy(input logic val, input string tag);
        int n = 0;
        @(negedge clk);
        while (busy_o !== val && n < 60) begin
            n++;
            @(negedge clk);
        end
        if (busy_o !== val) check({tag, " busy handshake timeout"}, busy_o, val);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_cycle(input logic [7:0] a);
        host_data = a;
        astb_n = 1'b0;
        wait_busy(1'b1, "R4");
        astb_n = 1'b1;
        wait_busy(1'b0, "R4");
    endtask

    task automatic data_write(input logic [7:0] b);
        wr_n = 1'b0;
        host_data = b;
        dstb_n = 1'b0;
        wait_busy(1'b1, "R5");
        check("R6 no drive on write", data_oe_o, 1'b0);
        dstb_n = 1'b1;
        wait_busy(1'b0, "R5");
        wr_n = 1'b1;
    endtask

    task automatic data_read(output logic [7:0] b, output logic oe_seen);
        wr_n = 1'b1;
        dstb_n = 1'b0;
        wait_busy(1'b1, "R6");
        b = data_o;
        oe_seen = data_oe_o;
        dstb_n = 1'b1;
        wait_busy(1'b0, "R6");
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [15:0] w);
        addr_cycle(a);
        data_write(w[7:0]);
        data_write(w[15:8]);
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [15:0] w, output logic oe_ok);
        logic o0, o1;
        addr_cycle(a);
        data_read(w[7:0], o0);
        data_read(w[15:8], o1);
        oe_ok = o0 & o1;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                check("watchdog expired", 1, 0);
                finish_run();
            end
        end
    end

    initial begin
        logic [15:0] rd;
        logic        oe_ok;
        logic [7:0]  b;
        logic        o;

        idle(3);
        // R1 reset state while reset held
        check("R1 busy in reset", busy_o, 1'b0);
        check("R1 link lines in reset", {sel_o, perr_o, ack_n_o, fault_n_o, data_oe_o}, 5'b00110);
        rst = 1'b0;
        idle(3);
        check("R1 config after reset", {cfg_run, cfg_chan, cfg_bufsize, cfg_trig_lvl, cfg_trig_off, cfg_adc}, '0);

        // R3 strobes ignored before negotiation
        host_data = 8'h00;
        astb_n = 1'b0;
        idle(10);
        check("R3 no busy before negotiation", busy_o, 1'b0);
        astb_n = 1'b1;
        idle(4);

        // R12 wrong negotiation byte
        host_data = 8'h41;
        dstb_n = 1'b0;
        idle(8);
        check("R12 wrong code stays waiting", {perr_o, sel_o, ack_n_o}, 3'b001);
        dstb_n = 1'b1;
        idle(4);

        // R2 negotiation request
        host_data = 8'h40;
        dstb_n = 1'b0;
        idle(8);
        check("R2 negotiation reply", {perr_o, ack_n_o, fault_n_o, sel_o}, 4'b1011);
        wr_n = 1'b0;
        idle(6);
        dstb_n = 1'b1;
        wr_n = 1'b1;
        idle(8);
        check("R3 enhanced mode entered", {ack_n_o, sel_o, perr_o}, 3'b110);

        // R7 R8 R9 R10 R5 table of write then readback
        for (int i = 0; i < 11; i++) begin
            if (VECS[i].wr) reg_write(VECS[i].a, VECS[i].w);
            reg_read(VECS[i].a, rd, oe_ok);
            check($sformatf("R7 R8 R9 R10 table entry %0d", i), rd, VECS[i].e);
            check($sformatf("R6 drive during read %0d", i), oe_ok, 1'b1);
        end
        check("R6 released after read", data_oe_o, 1'b0);
        check("R5 R7 run port", cfg_run, 11'h55A);
        check("R5 bufsize port", cfg_bufsize, 14'h1234);
        check("R10 other regs kept", {cfg_chan, cfg_trig_lvl, cfg_trig_off, cfg_adc},
              {2'h3, 10'h3FF, 15'h7FFF, 12'hFFF});

        // R5 atomic update: half write leaves port unchanged
        addr_cycle(8'd3);
        data_write(8'hAB);
        idle(3);
        check("R5 half write not visible", cfg_trig_lvl, 10'h3FF);
        data_write(8'h01);
        idle(2);
        check("R5 commit on high byte", cfg_trig_lvl, 10'h1AB);

        // R11 snapshot between byte reads
        addr_cycle(8'd8);
        data_read(b, o);
        check("R11 low byte", b, 8'hAB);
        st_err = 1'b0; st_run = 1'b0; st_chan = 1'b0; st_sample = 10'h000;
        idle(5);
        data_read(b, o);
        check("R11 high byte from capture", b, 8'hC6);
        reg_read(8'd8, rd, oe_ok);
        check("R8 status after change", rd, 16'h0000);

        // R1 reset mid-operation
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(3);
        check("R1 config cleared by reset", {cfg_run, cfg_trig_lvl}, '0);
        check("R1 back to negotiation wait", {sel_o, busy_o}, 2'b00);

        finish_run();
    end
endmodule